// File: doc/BRIEF.md
# Asynchronous Subaction Sequencer

This block runs one asynchronous transfer on a shared serial bus, from the moment a local client asks for it until the bus is free again. A start request latches a source ID, a destination ID, a packet type and a payload length. The sequencer then asks the bus arbiter for control and waits for the win. Once it holds the bus, it sends a byte-serial packet: a four-byte header, the payload bytes it fetches by index from the client, and a 16-bit CRC. It then enforces the timed gaps that follow a subaction and checks the acknowledgement that comes back.

After the last packet byte is accepted, an acknowledgement gap gives the destination time to process the packet. Received bytes are ignored during this gap. A timeout window follows, in which the first acknowledgement byte must arrive. The three-byte acknowledgement carries the responder's ID pair and an action code. The pair must be the mirror image of the sent packet's IDs. A subaction gap of programmable length then keeps the bus idle. At the end of that gap, a one-cycle completion pulse reports the action code and any error. Gap and timeout lengths are given in clock cycles on input ports.

Top module: `subaction_seq`

## Requirements
- R1: After reset the block is idle: busy_o, arb_req_o, tx_valid_o and done_o are all low.
- R2: A start_i seen while idle raises arb_req_o from the next cycle. arb_req_o stays high, and tx_valid_o stays low, until arb_won_i is seen. The cycle after the win, tx_valid_o is high.
- R3: Packet bytes leave in this order: destination ID, source ID, type, payload length, the payload bytes (payload byte k is the value on pay_data_i while pay_idx_o = k), then the CRC high byte, then the CRC low byte. A byte is consumed on a cycle with tx_valid_o and tx_ready_i both high. While tx_ready_i is low, tx_valid_o and tx_data_o hold.
- R4: The CRC uses polynomial 0x1021, initial value 0xFFFF, no bit reflection and no final inversion. It covers the header and payload bytes, each taken most significant bit first.
- R5: The acknowledgement gap lasts exactly ack_gap_i cycles (at least 1) after the cycle that consumed the last CRC byte. A byte received during it is ignored.
- R6: If no received byte arrives within ack_tmo_i cycles (at least 1) after the acknowledgement gap, the completion reports err_noack_o high with done_code_o = 0.
- R7: The first acknowledgement byte must equal the sent source ID and the second must equal the sent destination ID. Otherwise the completion reports err_idmis_o high.
- R8: On completion after an acknowledgement, done_code_o equals bits [3:0] of the third acknowledgement byte.
- R9: done_o is a one-cycle pulse. It rises exactly sub_gap_i cycles after the cycle that took the last acknowledgement byte, or after the timeout expired. At the same time the block returns to idle.
- R10: A start_i seen while the block is busy is ignored.
- R11: The payload length may be any value from 0 to 255. With length 0 the CRC follows the header directly.
- R12: The subaction gap is longer than the acknowledgement gap for every accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a subaction (taken only when idle) |
| src_id_i | input | 8 | Own node ID |
| dst_id_i | input | 8 | Target node ID |
| ptype_i | input | 8 | Packet type code |
| len_i | input | 8 | Payload byte count |
| ack_gap_i | input | GAP_W | Acknowledgement gap in cycles |
| sub_gap_i | input | GAP_W | Subaction gap in cycles |
| ack_tmo_i | input | GAP_W | Acknowledgement start timeout in cycles |
| arb_req_o | output | 1 | Bus request to the arbiter |
| arb_won_i | input | 1 | Arbiter grants the bus |
| tx_valid_o | output | 1 | Transmit byte present |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Line side takes the byte |
| pay_idx_o | output | 8 | Index of the payload byte wanted |
| pay_data_i | input | 8 | Payload byte at pay_idx_o |
| rx_valid_i | input | 1 | Received byte present |
| rx_data_i | input | 8 | Received byte |
| busy_o | output | 1 | A subaction is in progress |
| done_o | output | 1 | Completion pulse |
| done_code_o | output | 4 | Acknowledgement action code |
| err_noack_o | output | 1 | No acknowledgement arrived (valid with done_o) |
| err_idmis_o | output | 1 | Acknowledgement IDs did not match (valid with done_o) |

## Verification
The assertions assume the following about the inputs:
- The subaction gap set at start exceeds the acknowledgement gap.
- Every gap and timeout value is at least one.
- pay_data_i holds steady while the same payload index is presented, so the transmit byte does not change while the line side stalls.

The stimulus keeps within these limits:
- Acknowledgement gaps are drawn from 1 to 6 cycles.
- Timeouts are drawn from 1 to 8 cycles.
- Subaction gaps are set to the acknowledgement gap plus 1 to 6 cycles.
- Payload bytes come from a table that changes only between transfers.

Acknowledgement delays are drawn below the timeout, except in the runs that test the missing acknowledgement.

// File: rtl/sa_pkg.sv
package sa_pkg;

    localparam int BYTE_W    = 8;
    localparam int HDR_BYTES = 4;
    localparam int ACK_BYTES = 3;
    localparam int IDX_W     = BYTE_W + 1;
    localparam int CODE_W    = 4;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_TX,
        ST_ACK_GAP,
        ST_ACK_WAIT,
        ST_ACK_RX,
        ST_SUB_GAP
    } sa_state_e;

    typedef struct packed {
        sa_state_e           st;
        logic [BYTE_W-1:0]   src;
        logic [BYTE_W-1:0]   dst;
        logic [BYTE_W-1:0]   ptype;
        logic [BYTE_W-1:0]   len;
        logic [IDX_W-1:0]    idx;
        logic                done;
        logic [CODE_W-1:0]   code;
        logic                e_noack;
        logic                e_idmis;
    } sa_ctl_t;

    // One byte of the CRC update, byte taken msb first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [BYTE_W-1:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/sa_crc16.sv
module sa_crc16
    import sa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [15:0]       crc_o
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr_i) begin
            crc_d = CRC_SEED;
        end else if (en_i) begin
            crc_d = crc16_step(crc_q, byte_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;

    // R4
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(crc_o));

endmodule

// File: rtl/sa_gap_timer.sv
module sa_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (val_i == '0) ? '0 : val_i - W'(1);
        end else if (dec_i && cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R9
    timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && zero_o) |=> zero_o);

endmodule

// File: rtl/sa_ack_capture.sv
module sa_ack_capture
    import sa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] exp_src_i,
    input  logic [BYTE_W-1:0] exp_dst_i,
    output logic [1:0]        cnt_o,
    output logic              ids_ok_o,
    output logic [CODE_W-1:0] code_o
);
    typedef struct packed {
        logic [1:0]        cnt;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
        logic [CODE_W-1:0] code;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (clr_i) begin
            cap_d = '0;
        end else if (take_i && cap_q.cnt != 2'(ACK_BYTES)) begin
            case (cap_q.cnt)
                2'd0:    cap_d.b0   = byte_i;
                2'd1:    cap_d.b1   = byte_i;
                default: cap_d.code = byte_i[CODE_W-1:0];
            endcase
            cap_d.cnt = cap_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cnt_o    = cap_q.cnt;
    assign ids_ok_o = (cap_q.b0 == exp_src_i) && (cap_q.b1 == exp_dst_i);
    assign code_o   = cap_q.code;

    // R8
    cap_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == 2'(ACK_BYTES) && !clr_i) |=> (cnt_o == 2'(ACK_BYTES)) && $stable(code_o));

endmodule

// File: rtl/subaction_seq.sv
module subaction_seq
    import sa_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        src_id_i,
    input  logic [7:0]        dst_id_i,
    input  logic [7:0]        ptype_i,
    input  logic [7:0]        len_i,
    input  logic [GAP_W-1:0]  ack_gap_i,
    input  logic [GAP_W-1:0]  sub_gap_i,
    input  logic [GAP_W-1:0]  ack_tmo_i,
    output logic              arb_req_o,
    input  logic              arb_won_i,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    input  logic              tx_ready_i,
    output logic [7:0]        pay_idx_o,
    input  logic [7:0]        pay_data_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [3:0]        done_code_o,
    output logic              err_noack_o,
    output logic              err_idmis_o
);
    localparam logic [IDX_W-1:0] HDR_N = IDX_W'(HDR_BYTES);

    sa_ctl_t ctl_d, ctl_q;

    logic             tmr_load, tmr_dec, tmr_zero;
    logic [GAP_W-1:0] tmr_val;
    logic             crc_clr, crc_en;
    logic [15:0]      crc_val;
    logic             cap_clr, cap_take;
    logic [1:0]       cap_cnt;
    logic             cap_ids_ok;
    logic [3:0]       cap_code;
    logic [7:0]       cur_byte;
    logic [IDX_W-1:0] pay_end, last_idx;

    assign pay_end  = HDR_N + {1'b0, ctl_q.len};
    assign last_idx = pay_end + IDX_W'(1);

    // Byte select for the packet being sent.
    always_comb begin
        if (ctl_q.idx == IDX_W'(0))        cur_byte = ctl_q.dst;
        else if (ctl_q.idx == IDX_W'(1))   cur_byte = ctl_q.src;
        else if (ctl_q.idx == IDX_W'(2))   cur_byte = ctl_q.ptype;
        else if (ctl_q.idx == IDX_W'(3))   cur_byte = ctl_q.len;
        else if (ctl_q.idx < pay_end)      cur_byte = pay_data_i;
        else if (ctl_q.idx == pay_end)     cur_byte = crc_val[15:8];
        else                               cur_byte = crc_val[7:0];
    end

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.done    = 1'b0;
        ctl_d.code    = '0;
        ctl_d.e_noack = 1'b0;
        ctl_d.e_idmis = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        cap_clr  = 1'b0;
        cap_take = 1'b0;

        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st    = ST_ARB;
                    ctl_d.src   = src_id_i;
                    ctl_d.dst   = dst_id_i;
                    ctl_d.ptype = ptype_i;
                    ctl_d.len   = len_i;
                    ctl_d.idx   = '0;
                    crc_clr     = 1'b1;
                    cap_clr     = 1'b1;
                end
            end
            ST_ARB: begin
                if (arb_won_i) begin
                    ctl_d.st  = ST_TX;
                    ctl_d.idx = '0;
                end
            end
            ST_TX: begin
                if (tx_ready_i) begin
                    if (ctl_q.idx < pay_end) begin
                        crc_en = 1'b1;
                    end
                    if (ctl_q.idx == last_idx) begin
                        ctl_d.st = ST_ACK_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = ack_gap_i;
                    end else begin
                        ctl_d.idx = ctl_q.idx + IDX_W'(1);
                    end
                end
            end
            ST_ACK_GAP: begin
                if (tmr_zero) begin
                    ctl_d.st = ST_ACK_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = ack_tmo_i;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_ACK_WAIT: begin
                if (rx_valid_i) begin
                    cap_take = 1'b1;
                    ctl_d.st = ST_ACK_RX;
                end else if (tmr_zero) begin
                    ctl_d.st = ST_SUB_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = sub_gap_i;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_ACK_RX: begin
                if (rx_valid_i) begin
                    cap_take = 1'b1;
                    if (cap_cnt == 2'(ACK_BYTES - 1)) begin
                        ctl_d.st = ST_SUB_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = sub_gap_i;
                    end
                end
            end
            ST_SUB_GAP: begin
                if (tmr_zero) begin
                    ctl_d.st      = ST_IDLE;
                    ctl_d.done    = 1'b1;
                    ctl_d.e_noack = (cap_cnt != 2'(ACK_BYTES));
                    ctl_d.e_idmis = (cap_cnt == 2'(ACK_BYTES)) && !cap_ids_ok;
                    ctl_d.code    = (cap_cnt == 2'(ACK_BYTES)) ? cap_code : '0;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sa_gap_timer #(.W(GAP_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .dec_i  (tmr_dec),
        .zero_o (tmr_zero)
    );

    sa_crc16 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (crc_clr),
        .en_i   (crc_en),
        .byte_i (cur_byte),
        .crc_o  (crc_val)
    );

    sa_ack_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cap_clr),
        .take_i    (cap_take),
        .byte_i    (rx_data_i),
        .exp_src_i (ctl_q.src),
        .exp_dst_i (ctl_q.dst),
        .cnt_o     (cap_cnt),
        .ids_ok_o  (cap_ids_ok),
        .code_o    (cap_code)
    );

    assign arb_req_o   = (ctl_q.st == ST_ARB);
    assign tx_valid_o  = (ctl_q.st == ST_TX);
    assign tx_data_o   = cur_byte;
    assign pay_idx_o   = ctl_q.idx[7:0] - 8'(HDR_BYTES);
    assign busy_o      = (ctl_q.st != ST_IDLE);
    assign done_o      = ctl_q.done;
    assign done_code_o = ctl_q.code;
    assign err_noack_o = ctl_q.e_noack;
    assign err_idmis_o = ctl_q.e_idmis;

    // R2
    arb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req_o && !arb_won_i) |=> (arb_req_o && !tx_valid_o));

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    noack_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_noack_o |-> (done_o && done_code_o == 4'd0 && !err_idmis_o));

    // R12
    gap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |-> (sub_gap_i > ack_gap_i));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o) |=> (busy_o || done_o));

endmodule

// File: tb/subaction_seq_bench.sv
module subaction_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] src_id_i = '0, dst_id_i = '0, ptype_i = '0, len_i = '0;
    logic [7:0] ack_gap_i = 8'd1, sub_gap_i = 8'd2, ack_tmo_i = 8'd1;
    logic       arb_req_o, arb_won_i = 1'b0;
    logic       tx_valid_o, tx_ready_i = 1'b0;
    logic [7:0] tx_data_o, pay_idx_o, pay_data_i;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_data_i = '0;
    logic       busy_o, done_o, err_noack_o, err_idmis_o;
    logic [3:0] done_code_o;

    logic [7:0] pay_mem [256];
    logic [7:0] exp_pkt [264];
    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign pay_data_i = pay_mem[pay_idx_o];

    subaction_seq u_subaction_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_id_i(src_id_i), .dst_id_i(dst_id_i), .ptype_i(ptype_i), .len_i(len_i),
        .ack_gap_i(ack_gap_i), .sub_gap_i(sub_gap_i), .ack_tmo_i(ack_tmo_i),
        .arb_req_o(arb_req_o), .arb_won_i(arb_won_i),
        .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
        .pay_idx_o(pay_idx_o), .pay_data_i(pay_data_i),
        .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
        .busy_o(busy_o), .done_o(done_o), .done_code_o(done_code_o),
        .err_noack_o(err_noack_o), .err_idmis_o(err_idmis_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Bitwise CRC model, one bit at a time.
    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[15] ^ exp_pkt[k][b];
                c  = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    task automatic send_rx(input logic [7:0] b, input bit gaps);
        if (gaps) repeat ($urandom % 2) @(negedge clk);
        rx_valid_i = 1'b1;
        rx_data_i  = b;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    // mode 0: good ack, 1: wrong IDs, 2: no ack
    task automatic run_txn(input logic [7:0] src, input logic [7:0] dst, input logic [7:0] len,
                           input int n_gap, input int n_tmo, input int n_sub, input int mode,
                           input int delay, input bit junk, input bit poke_start);
        logic [15:0] crc;
        logic [3:0]  code;
        int total, idx;
        code = 4'($urandom);
        for (int k = 0; k < 256; k++) pay_mem[k] = 8'($urandom);
        exp_pkt[0] = dst; exp_pkt[1] = src; exp_pkt[2] = 8'($urandom); exp_pkt[3] = len;
        for (int k = 0; k < int'(len); k++) exp_pkt[4+k] = pay_mem[k];
        crc = ref_crc(4 + int'(len));
        exp_pkt[4+int'(len)] = crc[15:8];
        exp_pkt[5+int'(len)] = crc[7:0];
        total = 6 + int'(len);

        src_id_i = src; dst_id_i = dst; ptype_i = exp_pkt[2]; len_i = len;
        ack_gap_i = 8'(n_gap); ack_tmo_i = 8'(n_tmo); sub_gap_i = 8'(n_sub);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(arb_req_o && busy_o, "R2 arb request", int'(arb_req_o), 1);
        repeat ($urandom % 4) begin
            @(negedge clk);
            check(arb_req_o && !tx_valid_o, "R2 wait for win", int'(tx_valid_o), 0);
        end
        arb_won_i = 1'b1;
        @(negedge clk);
        arb_won_i = 1'b0;
        check(tx_valid_o, "R2 tx after win", int'(tx_valid_o), 1);

        idx = 0;
        while (idx < total) begin
            bit rdy;
            check(tx_valid_o && tx_data_o == exp_pkt[idx], (idx >= total - 2) ? "R4 crc byte" : "R3 packet byte",
                  int'(tx_data_o), int'(exp_pkt[idx]));
            rdy = ($urandom % 3) != 0;
            tx_ready_i = rdy;
            @(negedge clk);
            tx_ready_i = 1'b0;
            if (rdy) idx++;
        end
        check(!tx_valid_o, "R3 end of packet", int'(tx_valid_o), 0);

        repeat (n_gap - 1) @(negedge clk);
        if (junk) send_rx(8'hA5, 1'b0);   // R5 last gap cycle, must be ignored
        else @(negedge clk);

        if (mode == 2) begin
            repeat (n_tmo + n_sub) begin
                check(!done_o, "R6 no early done", int'(done_o), 0);
                @(negedge clk);
            end
        end else begin
            repeat (delay) @(negedge clk);
            send_rx((mode == 1) ? (src ^ 8'h01) : src, 1'b0);
            send_rx(dst, 1'b1);
            send_rx({4'($urandom), code}, 1'b1);
            if (poke_start) begin
                start_i = 1'b1;   // R10 ignored while busy
                @(negedge clk);
                start_i = 1'b0;
                repeat (n_sub - 1) begin
                    check(!done_o, "R9 gap length", int'(done_o), 0);
                    @(negedge clk);
                end
            end else begin
                repeat (n_sub) begin
                    check(!done_o, "R9 gap length", int'(done_o), 0);
                    @(negedge clk);
                end
            end
        end
        check(done_o, "R9 done timing", int'(done_o), 1);
        check(err_noack_o == (mode == 2), "R6 noack flag", int'(err_noack_o), int'(mode == 2));
        check(err_idmis_o == (mode == 1), "R7 id check", int'(err_idmis_o), int'(mode == 1));
        check(done_code_o == ((mode == 2) ? 4'd0 : code), "R8 ack code", int'(done_code_o),
              int'((mode == 2) ? 4'd0 : code));
        @(negedge clk);
        check(!done_o && !busy_o && !arb_req_o, "R9 R10 idle after done", int'({done_o, busy_o, arb_req_o}), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy_o && !arb_req_o && !tx_valid_o && !done_o, "R1 reset idle",
              int'({busy_o, arb_req_o, tx_valid_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !arb_req_o, "R1 idle after release", int'(busy_o), 0);

        run_txn(8'h11, 8'h22, 8'd0, 1, 1, 2, 0, 0, 1'b0, 1'b0);   // R11 empty payload, minimal gaps
        run_txn(8'h33, 8'h44, 8'd5, 4, 6, 7, 0, 5, 1'b1, 1'b0);   // R5 junk in gap, R6 latest start
        run_txn(8'h55, 8'h66, 8'd3, 2, 3, 4, 2, 0, 1'b0, 1'b0);   // R6 missing ack
        run_txn(8'h77, 8'h88, 8'd2, 3, 4, 5, 1, 1, 1'b0, 1'b0);   // R7 wrong IDs
        run_txn(8'h99, 8'hAA, 8'd40, 2, 2, 6, 0, 0, 1'b0, 1'b1);  // R11 long payload, R10 start while busy
        run_txn(8'h01, 8'h02, 8'd255, 1, 2, 3, 0, 1, 1'b0, 1'b0); // R11 maximum length

        for (int t = 0; t < 30; t++) begin
            int g, tm, mode;
            g    = 1 + int'($urandom % 6);
            tm   = 1 + int'($urandom % 8);
            mode = int'($urandom % 3);
            run_txn(8'($urandom), 8'($urandom), 8'($urandom % 13), g, tm, g + 1 + int'($urandom % 6),
                    mode, int'($urandom % tm), ($urandom % 2) == 1, ($urandom % 4) == 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule